// File: doc/BRIEF.md
# SPI Slave Register-Access Frame Engine

This block is an SPI slave that turns fixed 16-bit frames into operations on a 64-entry register file kept outside the block. While chip select is low, the master shifts in a command byte and then a data byte, MSB first. The block answers in the same frame. It first returns a global status byte, then a response byte taken from the addressed location.

There are four operations: read, write, read-and-clear, and read-device-information. The device-information space is a separate read-only space. Its frame-identification byte sits at address 3Eh, and a master reads it first to learn the frame format.

A register update happens only when chip select rises after exactly sixteen clocks. A frame of any other length changes nothing and raises a sticky frame-error flag. That flag appears in the status byte of later frames.

The SPI lines are oversampled by the system clock through two-stage synchronisers. The block works in mode 0: SDI is captured on the rising SCK edge and SDO moves on the falling edge.

Top module: `spi_regframe`

## Requirements
- R1: A frame is 16 SCK rising edges with CSN low. SDI is sampled on each rising edge, MSB first. Bits 7:6 of the first byte are the operation code and bits 5:0 are the address. The second byte is the data.
- R2: The first SDO byte is the status byte, captured when CSN falls. Its bit 7 is the frame-error flag and bits 6:0 are `stat_in`. It is sent MSB first. Bit 7 is valid before the first rising edge, and each later bit follows a falling SCK edge.
- R3: Operation code 01 (read) returns the current content of the addressed register as the second SDO byte and leaves it unchanged.
- R4: Operation code 00 (write) returns the register's previous content as the second SDO byte. The data byte is written only when CSN rises after exactly 16 clocks.
- R5: Operation code 10 (read-and-clear) returns the register's content and then writes zero to it when a 16-clock frame ends.
- R6: Operation code 11 (device information) returns `INFO_ID` (default 8'h10) at address 3Eh and 8'h00 at any other address. It never writes the register file.
- R7: A frame with a clock count other than 16, whether shorter or longer, writes nothing and sets the frame-error flag.
- R8: The frame-error flag is cleared when a 16-clock frame completes, so the status byte of the next frame shows bit 7 low.
- R9: `sdo_en` is low whenever CSN is high and high during a frame. The pad is released while the slave is deselected.
- R10: After reset, the frame-error flag is clear, `sdo_en` is low and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock |
| sdi | input | 1 | Serial data in |
| stat_in | input | 7 | Device status bits reported in the status byte |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the SDO pad; low means high impedance |
| rf_addr | output | 6 | Register file address |
| rf_wr | output | 1 | One-cycle register write strobe |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register file read data at `rf_addr` |

## Verification
The main function is exercised with each operation code. Alternating, all-ones and all-zero data bytes are used, so a dropped or swapped bit in either shift path shows up, and writes go to addresses 00h and 3Fh to catch address truncation. A write followed by a read of the same location separates "previous content" from an echo of the data byte. A clear followed by a read shows that clearing happens after the response, not before it. Frames of 10 and 20 clocks, each followed by a good frame, show that a wrong-length frame blocks the update, that the error flag reaches the next status byte, and that one good frame clears it.

// File: rtl/spi_regframe.sv
module spi_regframe #(
  parameter int          AW        = 6,
  parameter int          DW        = 8,
  parameter logic [7:0]  INFO_ID   = 8'h10,
  parameter logic [5:0]  INFO_ADDR = 6'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csn,
  input  logic          sck,
  input  logic          sdi,
  input  logic [DW-2:0] stat_in,
  output logic          sdo,
  output logic          sdo_en,
  output logic [AW-1:0] rf_addr,
  output logic          rf_wr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int CMDW = AW + 2;
  localparam int FLEN = CMDW + DW;
  localparam int CW   = $clog2(FLEN) + 2;
  localparam logic [1:0] OP_WR = 2'b00, OP_RD = 2'b01, OP_CLR = 2'b10, OP_INFO = 2'b11;

  logic [2:0]      csn_q, sck_q;
  logic [1:0]      sdi_q;
  logic [CW-1:0]   cnt;
  logic [FLEN-1:0] shin;
  logic [CMDW-1:0] cmd;
  logic [DW-1:0]   obuf, resp;
  logic            ferr;

  wire csn_s    = csn_q[1];
  wire csn_fall = csn_q[2] & ~csn_q[1];
  wire csn_rise = ~csn_q[2] & csn_q[1];
  wire sck_rise = ~sck_q[2] & sck_q[1] & ~csn_s;
  wire sck_fall = sck_q[2] & ~sck_q[1] & ~csn_s;
  wire [1:0] op = cmd[CMDW-1 -: 2];

  assign rf_addr = cmd[AW-1:0];
  assign sdo     = obuf[DW-1];
  assign sdo_en  = ~csn_s;
  assign resp    = (op == OP_INFO) ? ((rf_addr == INFO_ADDR) ? INFO_ID : '0) : rf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= '1;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      csn_q <= {csn_q[1:0], csn};
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shin     <= '0;
      cmd      <= '0;
      obuf     <= '0;
      ferr     <= 1'b0;
      rf_wr    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_wr <= 1'b0;
      if (csn_fall) begin
        cnt  <= '0;
        obuf <= {ferr, stat_in};
      end
      if (sck_rise) begin
        shin <= {shin[FLEN-2:0], sdi_q[1]};
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (cnt == CW'(CMDW - 1)) cmd <= {shin[CMDW-2:0], sdi_q[1]};
      end
      if (sck_fall)
        obuf <= (cnt == CW'(CMDW)) ? resp : {obuf[DW-2:0], 1'b0};
      if (csn_rise) begin
        if (cnt == CW'(FLEN)) begin
          ferr <= 1'b0;
          if (op == OP_WR || op == OP_CLR) begin
            rf_wr    <= 1'b1;
            rf_wdata <= (op == OP_WR) ? shin[DW-1:0] : '0;
          end
        end else begin
          ferr <= 1'b1;
        end
      end
    end
  end

  p_wr_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> cnt == CW'(FLEN));
  p_wr_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (op == OP_WR || op == OP_CLR));
  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && op == OP_CLR) |-> rf_wdata == '0);
  p_ferr_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> $past(csn_rise));
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && cnt != '1 && !csn_fall) |=> cnt == $past(cnt) + 1'b1);
  p_status_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csn_fall |=> sdo == $past(ferr));
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_s) |-> !sdo_en);
  p_no_wr_op_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD) |-> !rf_wr);
endmodule

// File: tb/sim_spi_regframe.sv
module sim_spi_regframe;
  logic       clk = 0, rst_n = 0;
  logic       csn = 1, sck = 0, sdi = 0;
  logic [6:0] stat_in = 7'h55;
  logic       sdo, sdo_en, rf_wr;
  logic [5:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  logic       exp_ferr = 0;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  spi_regframe u0 (.clk, .rst_n, .csn, .sck, .sdi, .stat_in, .sdo, .sdo_en,
                   .rf_addr, .rf_wr, .rf_wdata, .rf_rdata);

  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_wr) mem[rf_addr] <= rf_wdata;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string rq);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic frame(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d,
                       input int n, input string rq);
    logic [15:0] fb = {op, a, d};
    logic [7:0]  rsp = (op == 2'b11) ? ((a == 6'h3E) ? 8'h10 : 8'h00) : exp_mem[a];
    logic [15:0] ex = {exp_ferr, stat_in, rsp};
    @(negedge clk) csn = 0;
    repeat (8) @(negedge clk);
    chk({7'b0, sdo_en}, 8'd1, "R9 enable in frame");
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? fb[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (i < 16)
        chk({7'b0, sdo}, {7'b0, ex[15-i]}, (i < 8) ? "R2 status bit" : rq);
      sck = 1;
      repeat (8) @(negedge clk);
      sck = 0;
    end
    repeat (8) @(negedge clk);
    csn = 1;
    repeat (12) @(negedge clk);
    chk({7'b0, sdo_en}, 8'd0, "R9 released when deselected");
    if (n == 16) begin
      if (op == 2'b00) exp_mem[a] = d;
      if (op == 2'b10) exp_mem[a] = 8'h00;
      exp_ferr = 0;
    end else exp_ferr = 1;
    begin
      int diff = 0;
      for (int k = 0; k < 64; k++) if (mem[k] !== exp_mem[k]) diff++;
      chk(8'(diff), 8'd0, (n == 16) ? "R4 register file contents" : "R7 no update on bad frame");
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      mem[k] = 8'(k * 3 + 1);
      exp_mem[k] = 8'(k * 3 + 1);
    end
    repeat (3) @(negedge clk);
    chk({7'b0, sdo_en}, 8'd0, "R10 reset enable");
    chk({7'b0, rf_wr}, 8'd0, "R10 reset write strobe");
    rst_n = 1;
    repeat (4) @(negedge clk);
    frame(2'b11, 6'h3E, 8'h00, 16, "R6 info id");
    frame(2'b11, 6'h05, 8'h00, 16, "R6 info other address");
    frame(2'b01, 6'h07, 8'h00, 16, "R3 read");
    frame(2'b00, 6'h07, 8'hA5, 16, "R4 write returns previous");
    frame(2'b01, 6'h07, 8'h00, 16, "R3 read after write");
    stat_in = 7'h2A;
    frame(2'b00, 6'h00, 8'h5A, 16, "R4 write address 00");
    frame(2'b00, 6'h3F, 8'hFF, 16, "R4 write address 3F");
    frame(2'b00, 6'h3F, 8'h00, 16, "R4 write zero over ones");
    frame(2'b00, 6'h3F, 8'hC3, 16, "R4 write again");
    frame(2'b10, 6'h3F, 8'h77, 16, "R5 clear returns content");
    frame(2'b01, 6'h3F, 8'h00, 16, "R5 read after clear");
    frame(2'b00, 6'h10, 8'h99, 10, "R7 short frame");
    frame(2'b01, 6'h10, 8'h00, 16, "R8 status shows error then clears");
    frame(2'b01, 6'h10, 8'h00, 16, "R8 error flag cleared");
    frame(2'b10, 6'h11, 8'h00, 20, "R7 long frame");
    frame(2'b00, 6'h11, 8'h3C, 16, "R1 write after long frame");
    frame(2'b01, 6'h11, 8'h00, 16, "R1 readback");
    frame(2'b11, 6'h3E, 8'hFF, 16, "R6 info no write");
    finish_run();
  end
endmodule